// File: doc/BRIEF.md
# Interrupt Enable and Breakpoint Unit

This block is the interrupt front end of a 16-bit processor subsystem. It holds a four-bit source enable register and one pending latch for each of four interrupt sources: a serial port (transmit and receive events merged), general-purpose pins, and two timers. A source event is latched only while its source is enabled. A request output is high while both the latch and the enable bit are set. For the pin and timer sources, clearing an enable bit also flushes that source's latch. For the serial source, clearing its enable bit only masks the request, and software clears the latch with a separate acknowledge write.

The unit also holds a 16-bit breakpoint address that is compared with the program counter on every cycle. A three-state machine tracks the comparator:

- `BP_IDLE`: the address is zero and the comparator is off.
- `BP_ARMED`: a nonzero address is held.
- `BP_HIT`: the breakpoint request is latched.

The transitions are:

- **arm**: `BP_IDLE` to `BP_ARMED` on a nonzero write.
- **disarm**: `BP_ARMED` to `BP_IDLE` on a zero write.
- **match**: `BP_ARMED` to `BP_HIT` when the program counter equals the address and no zero write happens in that cycle.
- **release**: `BP_HIT` to `BP_IDLE` on a zero write.

In `BP_HIT`, a nonzero write changes the address and the state stays `BP_HIT`. The only way to release the request is to write zero.

Software reaches the unit through a single-cycle write strobe, a 2-bit register select, 16-bit write data and combinational read data. Select 0 is the enable register, select 1 is the breakpoint address, and select 2 is the pending status on read and the acknowledge on write. Select 3 reads zero.

Top module: `irq_bkpt_unit`

## Requirements
- R1: The enable register sits at select 0 and resets to 0. Bit 3 enables the serial source, bit 2 the pin source, bit 1 timer 1 and bit 0 timer 0, with 1 meaning enabled.
- R2: Writes to enable-register bits 15..4 are dropped, and those bits always read as 0.
- R3: An event sets its source's pending latch at the next clock edge only while that source's enable bit is 1. Either serial event (transmit or receive) sets the serial latch.
- R4: Each request output is high exactly while its pending latch and its enable bit are both 1.
- R5: A write to select 0 with a 0 in bit 2, 1 or 0 clears that source's pending latch at the same edge, even if an event for that source arrives in the same cycle.
- R6: Clearing enable bit 3 masks the serial request but keeps its latch. A write to select 2 with bit 3 set clears the serial latch, unless a serial event arrives in the same cycle, in which case the latch stays set.
- R7: The breakpoint address sits at select 1, is 16 bits wide, is readable and writable, and resets to 0.
- R8: With a nonzero address held, the breakpoint request rises at the edge that ends a cycle in which the program counter equals the address.
- R9: While the address is 0, no program counter value, including 0, raises the breakpoint request.
- R10: The breakpoint request stays high after the program counter moves away and across nonzero writes. It falls only at the edge of a write of zero to select 1.
- R11: A match in the same cycle as a zero write to select 1 is dropped.
- R12: Reading select 2 returns the four pending latches in bits 3..0, in the same bit order as the enable register, with 0 in the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_sel | input | 2 | Register select: 0 enable, 1 breakpoint, 2 pending/acknowledge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| ev_uart_tx | input | 1 | Serial transmit event |
| ev_uart_rx | input | 1 | Serial receive event |
| ev_gpio | input | 1 | Pin event |
| ev_tmr1 | input | 1 | Timer 1 event |
| ev_tmr0 | input | 1 | Timer 0 event |
| pc | input | 16 | Program counter |
| irq_uart | output | 1 | Serial interrupt request |
| irq_gpio | output | 1 | Pin interrupt request |
| irq_tmr1 | output | 1 | Timer 1 interrupt request |
| irq_tmr0 | output | 1 | Timer 0 interrupt request |
| irq_bkpt | output | 1 | Breakpoint interrupt request |

## Verification
Every cycle, the assertions check the following:

- A latch never rises without its enable bit.
- A disable write flushes the pin and timer latches.
- The serial latch survives until it is acknowledged.
- A zero address never raises the breakpoint.
- The breakpoint request holds until a zero write, and that write always clears it.
- A match with a nonzero address is caught.

Only the bench's scenarios can show the rest. These are the register-select decoding, the reserved-bit read-back, and the re-appearance of a masked serial request after it is re-enabled. They also include the ordering of a serial event against an acknowledge in the same cycle, and a reset taken in the middle of operation.

// File: rtl/irq_bkpt_pkg.sv
package irq_bkpt_pkg;
    localparam int DATA_W   = 16;
    localparam int SEL_W    = 2;
    localparam int NUM_SRC  = 4;

    localparam int SRC_TMR0 = 0;
    localparam int SRC_TMR1 = 1;
    localparam int SRC_GPIO = 2;
    localparam int SRC_UART = 3;

    localparam logic [SEL_W-1:0] SEL_ENABLE = 2'd0;
    localparam logic [SEL_W-1:0] SEL_BKPT   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_PEND   = 2'd2;

    typedef enum logic [1:0] {
        BP_IDLE  = 2'd0,
        BP_ARMED = 2'd1,
        BP_HIT   = 2'd2
    } bp_state_e;
endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_bkpt_pkg::*;
#(
    parameter int NSRC     = NUM_SRC,
    parameter int HOLD_IDX = SRC_UART
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr,
    input  logic            ack_wr,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] ev,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] pend_q,
    output logic [NSRC-1:0] req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else if (en_wr) en_q <= wbits;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i == HOLD_IDX) begin : g_ack_clear
            // latch kept over disable; cleared by acknowledge, new event wins
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else if (ev[i] && en_q[i]) pend_q[i] <= 1'b1;
                else if (ack_wr && wbits[i]) pend_q[i] <= 1'b0;
            end

            assert_uart_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[i] && !(ack_wr && wbits[i])) |=> pend_q[i]);
        end else begin : g_flush_clear
            // disable write flushes latch, takes precedence over an event
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend_q[i] <= 1'b0;
                else if (en_wr && !wbits[i]) pend_q[i] <= 1'b0;
                else if (ev[i] && en_q[i]) pend_q[i] <= 1'b1;
            end

            assert_disable_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (en_wr && !wbits[i]) |=> !pend_q[i]);
        end

        assign req[i] = pend_q[i] & en_q[i];

        assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[i] && !en_q[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/bkpt_fsm.sv
module bkpt_fsm
    import irq_bkpt_pkg::*;
#(
    parameter int AW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] addr_q,
    output logic          hit
);
    bp_state_e state_q, state_d;
    logic      zero_wr;

    assign zero_wr = wr_en && (wdata == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else if (wr_en) addr_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BP_IDLE;
        else state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BP_IDLE:  if (wr_en && !zero_wr) state_d = BP_ARMED;
            BP_ARMED: begin
                if (zero_wr) state_d = BP_IDLE;
                else if (pc == addr_q) state_d = BP_HIT;
            end
            BP_HIT:   if (zero_wr) state_d = BP_IDLE;
            default:  state_d = BP_IDLE;
        endcase
    end

    always_comb begin
        hit = (state_q == BP_HIT);
    end

    assert_zero_never_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q == '0 && !hit) |=> !hit);
    assert_hit_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !zero_wr) |=> hit);
    assert_zero_write_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !hit);
    assert_match_caught_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q != '0 && pc == addr_q && !zero_wr) |=> hit);
endmodule

// File: rtl/irq_bkpt_unit.sv
module irq_bkpt_unit
    import irq_bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_uart_tx,
    input  logic              ev_uart_rx,
    input  logic              ev_gpio,
    input  logic              ev_tmr1,
    input  logic              ev_tmr0,
    input  logic [DATA_W-1:0] pc,
    output logic              irq_uart,
    output logic              irq_gpio,
    output logic              irq_tmr1,
    output logic              irq_tmr0,
    output logic              irq_bkpt
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    logic [NUM_SRC-1:0] ev, en_q, pend_q, req;
    logic [DATA_W-1:0]  bp_addr;
    logic               en_wr, ack_wr, bp_wr;

    assign en_wr  = reg_wr_en && (reg_sel == SEL_ENABLE);
    assign bp_wr  = reg_wr_en && (reg_sel == SEL_BKPT);
    assign ack_wr = reg_wr_en && (reg_sel == SEL_PEND);

    always_comb begin
        ev = '0;
        ev[SRC_UART] = ev_uart_tx | ev_uart_rx;
        ev[SRC_GPIO] = ev_gpio;
        ev[SRC_TMR1] = ev_tmr1;
        ev[SRC_TMR0] = ev_tmr0;
    end

    irq_enable_regs #(.NSRC(NUM_SRC), .HOLD_IDX(SRC_UART)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (en_wr),
        .ack_wr (ack_wr),
        .wbits  (reg_wdata[NUM_SRC-1:0]),
        .ev     (ev),
        .en_q   (en_q),
        .pend_q (pend_q),
        .req    (req)
    );

    bkpt_fsm #(.AW(DATA_W)) u_bp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bp_wr),
        .wdata  (reg_wdata),
        .pc     (pc),
        .addr_q (bp_addr),
        .hit    (irq_bkpt)
    );

    always_comb begin
        case (reg_sel)
            SEL_ENABLE: reg_rdata = {{PAD_W{1'b0}}, en_q};
            SEL_BKPT:   reg_rdata = bp_addr;
            SEL_PEND:   reg_rdata = {{PAD_W{1'b0}}, pend_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_uart = req[SRC_UART];
    assign irq_gpio = req[SRC_GPIO];
    assign irq_tmr1 = req[SRC_TMR1];
    assign irq_tmr0 = req[SRC_TMR0];

    assert_masked_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q[SRC_UART]) |-> !irq_uart);
endmodule

// File: tb/irq_bkpt_unit_test.sv
`timescale 1ns/1ps
module irq_bkpt_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ev_uart_tx = 0, ev_uart_rx = 0, ev_gpio = 0, ev_tmr1 = 0, ev_tmr0 = 0;
    logic [15:0] pc = 16'h1000;
    logic        irq_uart, irq_gpio, irq_tmr1, irq_tmr0, irq_bkpt;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    irq_bkpt_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_uart_tx(ev_uart_tx), .ev_uart_rx(ev_uart_rx), .ev_gpio(ev_gpio),
        .ev_tmr1(ev_tmr1), .ev_tmr0(ev_tmr0), .pc(pc),
        .irq_uart(irq_uart), .irq_gpio(irq_gpio), .irq_tmr1(irq_tmr1),
        .irq_tmr0(irq_tmr0), .irq_bkpt(irq_bkpt)
    );

    // vector: wr | sel[2] | wdata[16] | ev{tx,rx,gpio,t1,t0} | pc[16] | irq{uart,gpio,t1,t0,bp} | rdata[16]
    localparam int NV = 22;
    localparam logic [60:0] VEC [NV] = '{
        {1'b0, 2'd0, 16'h0000, 5'b11111, 16'h1000, 5'b00000, 16'h0000}, // R3 disabled events ignored
        {1'b1, 2'd0, 16'hFFFF, 5'b00000, 16'h1000, 5'b00000, 16'h000F}, // R2 reserved bits drop
        {1'b0, 2'd2, 16'h0000, 5'b00111, 16'h1000, 5'b01110, 16'h0007}, // R3 gpio/t1/t0 latch
        {1'b0, 2'd2, 16'h0000, 5'b01000, 16'h1000, 5'b11110, 16'h000F}, // R3 uart rx latch
        {1'b1, 2'd0, 16'h000A, 5'b00000, 16'h1000, 5'b10100, 16'h000A}, // R5 flush gpio,t0
        {1'b0, 2'd2, 16'h0000, 5'b00000, 16'h1000, 5'b10100, 16'h000A}, // R12 pending readback
        {1'b1, 2'd0, 16'h0002, 5'b00000, 16'h1000, 5'b00100, 16'h0002}, // R6 uart masked
        {1'b0, 2'd2, 16'h0000, 5'b00000, 16'h1000, 5'b00100, 16'h000A}, // R6 uart latch kept
        {1'b1, 2'd0, 16'h000F, 5'b00000, 16'h1000, 5'b10100, 16'h000F}, // R4 request returns
        {1'b1, 2'd2, 16'h0008, 5'b00000, 16'h1000, 5'b00100, 16'h0002}, // R6 ack clears
        {1'b1, 2'd2, 16'h0008, 5'b10000, 16'h1000, 5'b10100, 16'h000A}, // R6 event beats ack
        {1'b1, 2'd0, 16'h000D, 5'b00010, 16'h1000, 5'b10000, 16'h000D}, // R5 flush beats event
        {1'b1, 2'd2, 16'h0008, 5'b00000, 16'h1000, 5'b00000, 16'h0000}, // R6 ack again
        {1'b0, 2'd1, 16'h0000, 5'b00000, 16'h0000, 5'b00000, 16'h0000}, // R9 pc 0 no hit
        {1'b1, 2'd1, 16'h0400, 5'b00000, 16'h1000, 5'b00000, 16'h0400}, // R7 write addr
        {1'b0, 2'd1, 16'h0000, 5'b00000, 16'h0400, 5'b00001, 16'h0400}, // R8 match
        {1'b0, 2'd1, 16'h0000, 5'b00000, 16'h1000, 5'b00001, 16'h0400}, // R10 held
        {1'b1, 2'd1, 16'h0500, 5'b00000, 16'h1000, 5'b00001, 16'h0500}, // R10 nonzero write keeps
        {1'b1, 2'd1, 16'h0000, 5'b00000, 16'h1000, 5'b00000, 16'h0000}, // R10 zero write clears
        {1'b1, 2'd1, 16'h0500, 5'b00000, 16'h1000, 5'b00000, 16'h0500}, // R7 re-arm
        {1'b1, 2'd1, 16'h0000, 5'b00000, 16'h0500, 5'b00000, 16'h0000}, // R11 match dropped
        {1'b0, 2'd1, 16'h0000, 5'b00000, 16'h0500, 5'b00000, 16'h0000}  // R9 zero disarmed
    };
    string VREQ [NV] = '{"R3", "R2", "R3", "R3", "R5", "R12", "R6", "R6", "R4", "R6", "R6",
                         "R5", "R6", "R9", "R7", "R8", "R10", "R10", "R10", "R7", "R11", "R9"};

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] irqs();
        return {irq_uart, irq_gpio, irq_tmr1, irq_tmr0, irq_bkpt};
    endfunction

    task automatic drive(input logic wr, input logic [1:0] sel, input logic [15:0] wd,
                         input logic [4:0] ev, input logic [15:0] p);
        reg_wr_en = wr; reg_sel = sel; reg_wdata = wd; pc = p;
        {ev_uart_tx, ev_uart_rx, ev_gpio, ev_tmr1, ev_tmr0} = ev;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL all watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R1 R7 R12
        check("R1", "irq after reset", {11'd0, irqs()}, 16'h0000);
        reg_sel = 2'd0; #1 check("R1", "enable reset", reg_rdata, 16'h0000);
        reg_sel = 2'd1; #1 check("R7", "bkpt reset", reg_rdata, 16'h0000);
        reg_sel = 2'd2; #1 check("R12", "pending reset", reg_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][60], VEC[i][59:58], VEC[i][57:42], VEC[i][41:37], VEC[i][36:21]);
            @(posedge clk);
            @(negedge clk);
            check(VREQ[i], $sformatf("vec %0d irq", i), {11'd0, irqs()}, {11'd0, VEC[i][20:16]});
            check(VREQ[i], $sformatf("vec %0d rdata", i), reg_rdata, VEC[i][15:0]);
        end

        // R1: single-bit enable mapping, timer 0 only
        drive(1, 2'd0, 16'h0001, 5'b00000, 16'h1000);
        @(posedge clk); @(negedge clk);
        drive(0, 2'd0, 16'h0000, 5'b11111, 16'h1000);
        @(posedge clk); @(negedge clk);
        check("R1", "bit0 enables timer0 only", {11'd0, irqs()}, 16'h0002);

        // R8 with a nonzero match then reset in the middle of operation
        drive(1, 2'd0, 16'h000F, 5'b00000, 16'h1000);
        @(posedge clk); @(negedge clk);
        drive(1, 2'd1, 16'h0020, 5'b00100, 16'h1000);
        @(posedge clk); @(negedge clk);
        drive(0, 2'd1, 16'h0000, 5'b00000, 16'h0020);
        @(posedge clk); @(negedge clk);
        check("R8", "hit at 0x0020", {15'd0, irq_bkpt}, 16'h0001);
        drive(0, 2'd0, 16'h0000, 5'b00000, 16'h1000);
        rst_n = 1'b0;
        #1 check("R1", "mid reset irqs", {11'd0, irqs()}, 16'h0000);
        check("R1", "mid reset enable", reg_rdata, 16'h0000);
        reg_sel = 2'd1; #1 check("R7", "mid reset bkpt", reg_rdata, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(0, 2'd1, 16'h0000, 5'b00000, 16'h0000);
        @(posedge clk); @(negedge clk);
        check("R9", "pc 0 after reset", {15'd0, irq_bkpt}, 16'h0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule